// File: doc/BRIEF.md
# Prescaled Countdown Interrupt Timer

This block is a per-core interval timer that software programs through three memory-mapped registers, with a fourth register that shows the live count. The timer entry register holds the interrupt vector, a mask bit and a mode bit. The divide register selects a power-of-two prescale of the core clock. Writing a starting value to the load register arms the countdown.

The counter decrements once per prescaled tick. When it steps from one to zero, the block issues a one-cycle interrupt request that carries the programmed vector, unless the entry is masked. In periodic mode the counter reloads the stored starting value on that tick and keeps running. In one-shot mode it parks at zero until software writes a new start value. Arbitration and delivery of the request belong to the logic downstream.

Top module: `lvt_countdown_timer`

## Requirements
- R1: After reset the current count reads 0, the timer entry reads 0x0001_0000 (masked, one-shot, vector 0), the divide register reads 0 and `irq_valid` is low.
- R2: The divide register is 4 bits wide and uses bits 3, 1 and 0. Bit 2 is ignored and reads back as 0. The code 1011 divides by 1. The codes 0000, 0001, 0010, 0011, 1000, 1001 and 1010 divide by 2, 4, 8, 16, 32, 64 and 128.
- R3: A write of N to offset 0x380 loads the counter with N and restarts the prescaler. A read of offset 0x390 returns the current count. The count drops by one on each prescaled tick.
- R4: With divisor D and a nonzero N, `irq_valid` is high for exactly the one cycle that follows the N*D-th rising edge after the write edge. `irq_vector` then equals the entry's bits 7:0.
- R5: In one-shot mode (entry bit 17 = 0) the count stays at 0 after expiry, and no further request is raised until the load register is written again.
- R6: In periodic mode (entry bit 17 = 1) the counter reloads N on the expiring tick, so requests repeat every N*D cycles.
- R7: When entry bit 16 = 1, no request is raised, but the counter still counts down and expires as usual.
- R8: Writing 0 to the load register stops the timer. The count reads 0 and no request follows.
- R9: The timer entry lives at offset 0x320. It reads back bits 7:0, 16 and 17 as written and all other bits as 0. Read data appears on `rd_data` in the cycle after `rd_en`, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The bench builds the timer with its default parameters: a 32-bit count, a 12-bit offset bus and an 8-bit vector. Start values are kept small, so even the divide-by-128 setting expires within a few hundred cycles. This puts every one of the eight divide codes within reach, as well as both aliases created by the ignored bit 2. The bench predicts the exact expiry cycle from N times D and checks it, checks the back-to-back count reads right after a load, and runs the periodic, masked and stop-by-zero cases end to end at the ports.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;
  localparam int PRE_W   = 7;   // log2 of the largest divisor
  localparam int SHIFT_W = 3;
  localparam logic [11:0] OFS_ENTRY = 12'h320;
  localparam logic [11:0] OFS_START = 12'h380;
  localparam logic [11:0] OFS_COUNT = 12'h390;
  localparam logic [11:0] OFS_DIV   = 12'h3E0;
  localparam int BIT_MASK  = 16;
  localparam int BIT_PERIO = 17;
  localparam logic [3:0] DIV_RESET = 4'b0000;
endpackage

// File: rtl/ltmr_prescaler.sv
module ltmr_prescaler
  import lvt_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic [3:0] div_code,
  output logic       tick
);
  logic [PRE_W-1:0]   pcnt;
  logic [PRE_W-1:0]   low_mask;
  logic [SHIFT_W-1:0] shift;

  // bits {3,1,0} plus one give log2 of the divisor, and 3'b111 wraps to 0 (divide by 1)
  assign shift = {div_code[3], div_code[1:0]} + SHIFT_W'(1);

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      low_mask[i] = (i < int'(shift));
    end
  end

  assign tick = &(pcnt | ~low_mask);

  always_ff @(posedge clk) begin
    if (rst || clear) pcnt <= '0;
    else              pcnt <= pcnt + PRE_W'(1);
  end

  assert_clear_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pcnt == '0));
  assert_unit_divide_ticks_R2: assert property (@(posedge clk) disable iff (rst)
    (div_code[3] && div_code[1:0] == 2'b11) |-> tick);
endmodule

// File: rtl/ltmr_regs.sv
module ltmr_regs
  import lvt_timer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  live_count,
  output logic [DATA_W-1:0] rd_data,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  start_q,
  output logic [VEC_W-1:0]  vector_q,
  output logic              masked_q,
  output logic              periodic_q,
  output logic [3:0]        div_q
);
  logic hit_entry, hit_start, hit_count, hit_div;
  logic [DATA_W-1:0] rd_mux;

  assign hit_entry = (addr == ADDR_W'(OFS_ENTRY));
  assign hit_start = (addr == ADDR_W'(OFS_START));
  assign hit_count = (addr == ADDR_W'(OFS_COUNT));
  assign hit_div   = (addr == ADDR_W'(OFS_DIV));

  assign load_stb = wr_en && hit_start;
  assign load_val = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q    <= '0;
      vector_q   <= '0;
      masked_q   <= 1'b1;
      periodic_q <= 1'b0;
      div_q      <= DIV_RESET;
    end else if (wr_en) begin
      if (hit_start) start_q <= load_val;
      if (hit_entry) begin
        vector_q   <= wr_data[VEC_W-1:0];
        masked_q   <= wr_data[BIT_MASK];
        periodic_q <= wr_data[BIT_PERIO];
      end
      if (hit_div) div_q <= {wr_data[3], 1'b0, wr_data[1:0]};
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_entry) begin
      rd_mux[VEC_W-1:0] = vector_q;
      rd_mux[BIT_MASK]  = masked_q;
      rd_mux[BIT_PERIO] = periodic_q;
    end else if (hit_start) begin
      rd_mux[CNT_W-1:0] = start_q;
    end else if (hit_count) begin
      rd_mux[CNT_W-1:0] = live_count;
    end else if (hit_div) begin
      rd_mux[3:0] = div_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assert_div_bit2_clear_R2: assert property (@(posedge clk) disable iff (rst)
    div_q[2] == 1'b0);
  assert_entry_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_entry) |=> (vector_q == $past(wr_data[VEC_W-1:0])));
endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_q,
  input  logic             tick,
  input  logic             masked,
  input  logic             periodic,
  input  logic [VEC_W-1:0] vector,
  output logic [CNT_W-1:0] count_q,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  logic run_q;
  logic expire;

  assign expire = run_q && tick && (count_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= '0;
      run_q      <= 1'b0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= 1'b0;
      if (load_stb) begin
        count_q <= load_val;
        run_q   <= (load_val != '0);
      end else if (expire) begin
        irq_valid  <= !masked;
        irq_vector <= vector;
        if (periodic) begin
          count_q <= start_q;
        end else begin
          count_q <= '0;
          run_q   <= 1'b0;
        end
      end else if (run_q && tick) begin
        count_q <= count_q - CNT_W'(1);
      end
    end
  end

  assert_masked_silent_R7: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(masked));
  assert_irq_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ($past(run_q) && $past(tick)));
  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !load_stb) |=> (count_q == $past(count_q)));
  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && !load_stb && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - CNT_W'(1)));
  assert_zero_load_stops_R8: assert property (@(posedge clk) disable iff (rst)
    (load_stb && load_val == '0) |=> (!run_q && count_q == '0));
endmodule

// File: rtl/lvt_countdown_timer.sv
module lvt_countdown_timer #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic             load_stb, masked_q, periodic_q, tick;
  logic [CNT_W-1:0] load_val, start_q, count_q;
  logic [VEC_W-1:0] vector_q;
  logic [3:0]       div_q;

  ltmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .live_count(count_q), .rd_data(rd_data),
    .load_stb(load_stb), .load_val(load_val), .start_q(start_q),
    .vector_q(vector_q), .masked_q(masked_q), .periodic_q(periodic_q), .div_q(div_q)
  );

  ltmr_prescaler u_pre (
    .clk(clk), .rst(rst), .clear(load_stb), .div_code(div_q), .tick(tick)
  );

  ltmr_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
    .clk(clk), .rst(rst), .load_stb(load_stb), .load_val(load_val),
    .start_q(start_q), .tick(tick), .masked(masked_q), .periodic(periodic_q),
    .vector(vector_q), .count_q(count_q), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );
endmodule

// File: tb/tb_lvt_countdown_timer.sv
module tb_lvt_countdown_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lvt_countdown_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  localparam logic [11:0] A_ENT = 12'h320, A_START = 12'h380, A_CNT = 12'h390, A_DIV = 12'h3E0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks begin and end just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // watch up to maxc cycles after a load: first irq cycle, its vector, irq count
  task automatic watch(input int maxc, output int first, output logic [7:0] vec, output int cnt);
    first = -1; vec = '0; cnt = 0;
    for (int k = 1; k <= maxc; k++) begin
      @(negedge clk);
      if (irq_valid) begin
        cnt++;
        if (first < 0) begin first = k; vec = irq_vector; end
      end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'b0, irq_valid}, 32'd0);
    rd(A_CNT, d);   check("R1 count", d, 32'd0);
    rd(A_ENT, d);   check("R1 entry", d, 32'h0001_0000);
    rd(A_DIV, d);   check("R1 div", d, 32'd0);
  endtask

  task automatic t_divide(input logic [3:0] code, input int dv, input logic [3:0] rb);
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(A_DIV, {28'b0, code});
    rd(A_DIV, d); check("R2 div readback", d, {28'b0, rb});
    wr(A_ENT, 32'h0000_0040 | dv);
    wr(A_START, 32'd3);
    watch(3 * dv + 8, f, v, c);
    check("R2 R4 expiry cycle", f, 3 * dv);
    check("R4 vector", {24'b0, v}, 32'h40 | dv);
    check("R4 single request", c, 32'd1);
  endtask

  task automatic t_oneshot;
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(A_DIV, 32'hB);
    wr(A_ENT, 32'h0000_00A5);
    wr(A_START, 32'd50);
    rd(A_CNT, d); check("R3 count after load", d, 32'd50);
    rd(A_CNT, d); check("R3 count one tick on", d, 32'd49);
    wr(A_START, 32'd5);
    watch(40, f, v, c);
    check("R4 one-shot expiry", f, 32'd5);
    check("R5 no repeat", c, 32'd1);
    rd(A_CNT, d); check("R5 parked at zero", d, 32'd0);
  endtask

  task automatic t_periodic;
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(A_DIV, 32'hB);
    wr(A_ENT, 32'h0002_0033);
    wr(A_START, 32'd4);
    watch(13, f, v, c);
    check("R6 first period", f, 32'd4);
    check("R6 three requests in 13", c, 32'd3);
    check("R6 vector", {24'b0, v}, 32'h33);
    wr(A_START, 32'd0);
  endtask

  task automatic t_masked;
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(A_DIV, 32'hB);
    wr(A_ENT, 32'h0001_0011);
    wr(A_START, 32'd10);
    rd(A_CNT, d); check("R7 count loaded", d, 32'd10);
    rd(A_CNT, d); check("R7 still counting", d, 32'd9);
    watch(30, f, v, c);
    check("R7 no request", c, 32'd0);
    rd(A_CNT, d); check("R7 expired to zero", d, 32'd0);
  endtask

  task automatic t_stop;
    int f, c; logic [7:0] v; logic [31:0] d;
    wr(A_DIV, 32'hB);
    wr(A_ENT, 32'h0000_0077);
    wr(A_START, 32'd100);
    repeat (5) @(negedge clk);
    wr(A_START, 32'd0);
    rd(A_CNT, d); check("R8 count zero", d, 32'd0);
    watch(150, f, v, c);
    check("R8 no request", c, 32'd0);
  endtask

  task automatic t_entry;
    logic [31:0] d;
    wr(A_ENT, 32'hFFFF_FFFF);
    rd(A_ENT, d); check("R9 entry fields", d, 32'h0003_00FF);
    rd(12'h3F0, d); check("R9 unmapped", d, 32'd0);
    wr(A_ENT, 32'h0001_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_divide(4'b1011, 1, 4'b1011);
    t_divide(4'b0000, 2, 4'b0000);
    t_divide(4'b0001, 4, 4'b0001);
    t_divide(4'b0010, 8, 4'b0010);
    t_divide(4'b0011, 16, 4'b0011);
    t_divide(4'b1000, 32, 4'b1000);
    t_divide(4'b1001, 64, 4'b1001);
    t_divide(4'b1010, 128, 4'b1010);
    t_divide(4'b1111, 1, 4'b1011);
    t_divide(4'b0100, 2, 4'b0000);
    t_oneshot();
    t_periodic();
    t_masked();
    t_stop();
    t_entry();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule